// File: doc/BRIEF.md
# Frame-Buffer Rectangle Fill and Copy Engine

This block draws into a byte-addressed frame buffer that lives outside it. It runs two operations: a solid rectangle fill and a rectangle copy from one place in the surface to another. Each pixel is 1 to 4 bytes wide. The byte address of pixel (x, y) is `pix_bytes*x + line_stride*y`. Every rectangle is checked against fixed maximum dimensions and against the current surface size before any byte is touched. An operation is started with a one-cycle `op_start` while the engine is idle. It ends with a one-cycle `op_done` or `op_error`.

When an operation succeeds, its destination rectangle is written into a circular dirty-region ring. A one-cycle `flush` drains the ring to the `upd_*` outputs, one rectangle per cycle, in the order the rectangles were queued. If `invalidate` is high with the flush, the queued rectangles are dropped instead, because the whole screen is about to be redrawn anyway. Copies choose their row order from the vertical relation of source and destination, and they stage each row in an internal buffer. This makes overlapping copies correct in every direction.

Top module: `fb_rect_engine`

## Requirements
- R1: A rectangle passes the bounds check only if all of the following hold: x >= 0, x <= MAX_W, w >= 0, w <= MAX_W, x + w <= surf_w, y >= 0, y <= MAX_H, h >= 0, h <= MAX_H and y + h <= surf_h. A failing operation gives a one-cycle `op_error`, writes no memory byte and queues no rectangle.
- R2: A `pix_bytes` value outside 1..4 makes the operation fail in the same way as R1.
- R3: A fill (`op_kind` = 0) writes byte k of every pixel with `op_colour[8k+7:8k]`, for k = 0 .. pix_bytes-1, over every row of the destination rectangle. No byte outside that rectangle is written.
- R4: A copy (`op_kind` = 1) checks both the source rectangle and the destination rectangle, and fails if either one fails. On success, the destination holds the bytes the source held before the copy.
- R5: When dst_y > src_y, a copy moves rows from the last row to the first; otherwise it moves them from the first row to the last. A copy whose source and destination overlap vertically gives the original source contents.
- R6: A copy with dst_y = src_y and dst_x > src_x (overlap within a row) gives the original source contents.
- R7: `op_done` and `op_error` are one-cycle pulses and never high together. `op_start` is ignored while `busy` is high, and such an ignored start causes no write and no completion.
- R8: Each successful operation queues its destination rectangle. A `flush` with `invalidate` low emits the queued rectangles in queue order on `upd_x`/`upd_y`/`upd_w`/`upd_h`, each qualified by `upd_valid`.
- R9: A `flush` with `invalidate` high emits nothing and drops every queued rectangle. A later flush emits none of the dropped rectangles.
- R10: The ring holds DQ_DEPTH entries (a power of two). Its write index wraps modulo DQ_DEPTH without a full check, so after n pushes only the last (n mod DQ_DEPTH) rectangles are emitted by the next flush.
- R11: A rectangle with zero width or zero height passes if R1 holds. It writes no byte, completes with `op_done` and is queued.
- R12: After reset, `busy`, `op_done`, `op_error` and `upd_valid` are low and the ring is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | Start pulse, accepted only while idle |
| op_kind | input | 1 | 0 = fill, 1 = copy |
| op_colour | input | 32 | Fill colour, byte k used for pixel byte k |
| src_x | input | CW | Copy source x (signed) |
| src_y | input | CW | Copy source y (signed) |
| dst_x | input | CW | Destination x (signed) |
| dst_y | input | CW | Destination y (signed) |
| rect_w | input | CW | Width in pixels (signed) |
| rect_h | input | CW | Height in rows (signed) |
| surf_w | input | CW | Surface width in pixels |
| surf_h | input | CW | Surface height in rows |
| line_stride | input | AW | Bytes from one row to the next |
| pix_bytes | input | 3 | Bytes per pixel |
| busy | output | 1 | An operation is running |
| op_done | output | 1 | Successful completion pulse |
| op_error | output | 1 | Bounds or format failure pulse |
| mem_rd_en | output | 1 | Frame-buffer read request |
| mem_rd_addr | output | AW | Read byte address |
| mem_rd_data | input | 8 | Read data, one cycle after the request |
| mem_wr_en | output | 1 | Frame-buffer byte write |
| mem_wr_addr | output | AW | Write byte address |
| mem_wr_data | output | 8 | Write data |
| flush | input | 1 | Drain request pulse |
| invalidate | input | 1 | With flush: drop queued rectangles |
| upd_valid | output | 1 | Dirty rectangle output valid |
| upd_x | output | CW | Dirty rectangle x |
| upd_y | output | CW | Dirty rectangle y |
| upd_w | output | CW | Dirty rectangle width |
| upd_h | output | CW | Dirty rectangle height |

## Verification
A wrong row order or a stale row buffer corrupts the overlapping part of a copy. A full memory comparison finds that right after `op_done`, so a second operation never hides it. A wrong colour phase counter shifts bytes inside a pixel, and this shows at the second byte of the first pixel a fill writes. A bad ring pointer appears at the next flush: the engine emits a rectangle that was never queued, skips one that was, or emits them out of order. The scoreboard flags this on the first `upd_valid` cycle that does not match. A wrong bounds decision shows on the completion pulse of that same operation.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  typedef enum logic {OP_FILL = 1'b0, OP_COPY = 1'b1} fbr_op_e;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FILL, ST_CP_RD, ST_CP_WAIT, ST_CP_WR, ST_FIN
  } fbr_state_e;
endpackage

// File: rtl/fbr_bounds.sv
module fbr_bounds #(
  parameter int CW    = 16,
  parameter int MAX_W = 64,
  parameter int MAX_H = 64
) (
  input  logic signed [CW-1:0] x,
  input  logic signed [CW-1:0] y,
  input  logic signed [CW-1:0] w,
  input  logic signed [CW-1:0] h,
  input  logic        [CW-1:0] lim_w,
  input  logic        [CW-1:0] lim_h,
  output logic                 ok
);
  localparam int EW = CW + 2;
  localparam logic signed [EW-1:0] LIM_XW = EW'(MAX_W);
  localparam logic signed [EW-1:0] LIM_YH = EW'(MAX_H);

  logic signed [EW-1:0] xe, ye, we, he, lw, lh;
  logic ok_h, ok_v;

  assign xe = x;
  assign ye = y;
  assign we = w;
  assign he = h;
  assign lw = {2'b00, lim_w};
  assign lh = {2'b00, lim_h};

  // horizontal and vertical legs are independent
  assign ok_h = (xe >= 0) && (xe <= LIM_XW) && (we >= 0) && (we <= LIM_XW) &&
                ((xe + we) <= lw);
  assign ok_v = (ye >= 0) && (ye <= LIM_YH) && (he >= 0) && (he <= LIM_YH) &&
                ((ye + he) <= lh);
  assign ok = ok_h && ok_v;
endmodule

// File: rtl/fbr_core.sv
module fbr_core
  import fbr_pkg::*;
#(
  parameter int CW    = 16,
  parameter int AW    = 16,
  parameter int MAX_W = 64,
  parameter int MAX_H = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 kind,
  input  logic [31:0]          colour,
  input  logic signed [CW-1:0] sx,
  input  logic signed [CW-1:0] sy,
  input  logic signed [CW-1:0] dx,
  input  logic signed [CW-1:0] dy,
  input  logic signed [CW-1:0] w,
  input  logic signed [CW-1:0] h,
  input  logic [CW-1:0]        surf_w,
  input  logic [CW-1:0]        surf_h,
  input  logic [AW-1:0]        stride,
  input  logic [2:0]           bpp,
  output logic                 busy,
  output logic                 done,
  output logic                 error,
  output logic                 mem_rd_en,
  output logic [AW-1:0]        mem_rd_addr,
  input  logic [7:0]           mem_rd_data,
  output logic                 mem_wr_en,
  output logic [AW-1:0]        mem_wr_addr,
  output logic [7:0]           mem_wr_data,
  output logic                 push,
  output logic [4*CW-1:0]      push_rect
);
  localparam int RB_DEPTH = MAX_W * 4;
  localparam int RB_W     = $clog2(RB_DEPTH + 1);
  localparam int RBA      = $clog2(RB_DEPTH);

  fbr_state_e state;
  fbr_op_e    kind_q;
  logic [31:0]    col_q;
  logic [CW-1:0]  sx_q, sy_q, dx_q, dy_q, w_q, h_q, r_q;
  logic [AW-1:0]  stride_q;
  logic [2:0]     bpp_q;
  logic           bottom_up_q;
  logic [RB_W-1:0] row_bytes_q, b_q;
  logic [1:0]     p_q;
  logic           rd_v1, rd_v2;
  logic [RBA-1:0] idx1, idx2;
  logic [7:0]     rowbuf [RB_DEPTH];

  logic src_ok, dst_ok, bpp_ok, good, accept, last_byte, last_row;
  logic [CW-1:0] row_sel;
  logic [AW-1:0] src_addr, dst_addr;
  logic [RB_W-1:0] row_bytes_d;

  fbr_bounds #(.CW(CW), .MAX_W(MAX_W), .MAX_H(MAX_H)) u_chk_dst (
    .x(dx), .y(dy), .w(w), .h(h), .lim_w(surf_w), .lim_h(surf_h), .ok(dst_ok));
  fbr_bounds #(.CW(CW), .MAX_W(MAX_W), .MAX_H(MAX_H)) u_chk_src (
    .x(sx), .y(sy), .w(w), .h(h), .lim_w(surf_w), .lim_h(surf_h), .ok(src_ok));

  assign bpp_ok      = (bpp >= 3'd1) && (bpp <= 3'd4);
  assign good        = dst_ok && bpp_ok && (fbr_op_e'(kind) == OP_FILL || src_ok);
  assign accept      = start && (state == ST_IDLE);
  assign row_bytes_d = RB_W'(w) * RB_W'(bpp);
  assign busy        = (state != ST_IDLE);

  assign last_byte = (b_q == row_bytes_q - RB_W'(1));
  assign last_row  = (r_q == h_q - CW'(1));
  assign row_sel   = bottom_up_q ? (h_q - CW'(1) - r_q) : r_q;
  assign dst_addr  = AW'(bpp_q) * AW'(dx_q) + stride_q * AW'(dy_q + row_sel) + AW'(b_q);
  assign src_addr  = AW'(bpp_q) * AW'(sx_q) + stride_q * AW'(sy_q + row_sel) + AW'(b_q);
  assign push_rect = {dx_q, dy_q, w_q, h_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      kind_q <= OP_FILL;
      col_q <= '0;
      sx_q <= '0; sy_q <= '0; dx_q <= '0; dy_q <= '0; w_q <= '0; h_q <= '0;
      stride_q <= '0; bpp_q <= 3'd1; bottom_up_q <= 1'b0;
      row_bytes_q <= '0; b_q <= '0; p_q <= '0; r_q <= '0;
      done <= 1'b0; error <= 1'b0; push <= 1'b0;
      mem_rd_en <= 1'b0; mem_rd_addr <= '0;
      mem_wr_en <= 1'b0; mem_wr_addr <= '0; mem_wr_data <= '0;
      rd_v1 <= 1'b0; rd_v2 <= 1'b0; idx1 <= '0; idx2 <= '0;
    end else begin
      done <= 1'b0; error <= 1'b0; push <= 1'b0;
      mem_rd_en <= 1'b0; mem_wr_en <= 1'b0;
      rd_v1 <= (state == ST_CP_RD);
      idx1  <= b_q[RBA-1:0];
      rd_v2 <= rd_v1;
      idx2  <= idx1;
      unique case (state)
        ST_IDLE: if (accept) begin
          if (!good) begin
            error <= 1'b1;
          end else begin
            kind_q <= fbr_op_e'(kind);
            col_q <= colour;
            sx_q <= sx; sy_q <= sy; dx_q <= dx; dy_q <= dy; w_q <= w; h_q <= h;
            stride_q <= stride; bpp_q <= bpp;
            bottom_up_q <= (fbr_op_e'(kind) == OP_COPY) && (dy > sy);
            row_bytes_q <= row_bytes_d;
            b_q <= '0; p_q <= '0; r_q <= '0;
            if (w == '0 || h == '0) state <= ST_FIN;
            else if (fbr_op_e'(kind) == OP_FILL) state <= ST_FILL;
            else state <= ST_CP_RD;
          end
        end
        ST_FILL: begin
          mem_wr_en   <= 1'b1;
          mem_wr_addr <= dst_addr;
          mem_wr_data <= col_q[{p_q, 3'b000} +: 8];
          if (last_byte) begin
            b_q <= '0; p_q <= '0;
            if (last_row) state <= ST_FIN;
            else r_q <= r_q + CW'(1);
          end else begin
            b_q <= b_q + RB_W'(1);
            p_q <= (3'(p_q) + 3'd1 == bpp_q) ? 2'd0 : p_q + 2'd1;
          end
        end
        ST_CP_RD: begin
          mem_rd_en   <= 1'b1;
          mem_rd_addr <= src_addr;
          if (last_byte) begin
            b_q <= '0;
            state <= ST_CP_WAIT;
          end else begin
            b_q <= b_q + RB_W'(1);
          end
        end
        ST_CP_WAIT: if (!rd_v1 && !rd_v2) state <= ST_CP_WR;
        ST_CP_WR: begin
          mem_wr_en   <= 1'b1;
          mem_wr_addr <= dst_addr;
          mem_wr_data <= rowbuf[b_q[RBA-1:0]];
          if (last_byte) begin
            b_q <= '0;
            if (last_row) state <= ST_FIN;
            else begin
              r_q <= r_q + CW'(1);
              state <= ST_CP_RD;
            end
          end else begin
            b_q <= b_q + RB_W'(1);
          end
        end
        ST_FIN: begin
          done  <= 1'b1;
          push  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // row staging buffer, no reset so it maps to RAM
  always_ff @(posedge clk) begin
    if (rd_v2) rowbuf[idx2] <= mem_rd_data;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R7
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst) !(done && error)); // R7
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (rst) error |-> (!mem_wr_en && !push)); // R1
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst) !(mem_rd_en && mem_wr_en)); // R5
  AST_WR_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst) mem_wr_en |-> $past(busy)); // R7
endmodule

// File: rtl/fbr_dirty_ring.sv
module fbr_dirty_ring #(
  parameter int EW    = 64,
  parameter int DEPTH = 512
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [EW-1:0] push_data,
  input  logic          flush,
  input  logic          invalidate,
  output logic          upd_valid,
  output logic [EW-1:0] upd_data
);
  localparam int PW = $clog2(DEPTH);

  logic [EW-1:0] ring [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          draining, rd_fire;

  assign rd_fire = draining && (rd_ptr != wr_ptr);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      draining <= 1'b0;
      upd_valid <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PW'(1);
      upd_valid <= rd_fire;
      if (draining) begin
        if (rd_fire) rd_ptr <= rd_ptr + PW'(1);
        else draining <= 1'b0;
      end else if (flush) begin
        if (invalidate) rd_ptr <= wr_ptr;
        else draining <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) ring[wr_ptr] <= push_data;
    if (rd_fire) upd_data <= ring[rd_ptr];
  end

  AST_INV_SILENT: assert property (@(posedge clk) disable iff (rst)
    (flush && invalidate && !draining) |=> !upd_valid); // R9
endmodule

// File: rtl/fb_rect_engine.sv
module fb_rect_engine #(
  parameter int CW       = 16,
  parameter int AW       = 16,
  parameter int MAX_W    = 64,
  parameter int MAX_H    = 64,
  parameter int DQ_DEPTH = 512
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 op_start,
  input  logic                 op_kind,
  input  logic [31:0]          op_colour,
  input  logic signed [CW-1:0] src_x,
  input  logic signed [CW-1:0] src_y,
  input  logic signed [CW-1:0] dst_x,
  input  logic signed [CW-1:0] dst_y,
  input  logic signed [CW-1:0] rect_w,
  input  logic signed [CW-1:0] rect_h,
  input  logic [CW-1:0]        surf_w,
  input  logic [CW-1:0]        surf_h,
  input  logic [AW-1:0]        line_stride,
  input  logic [2:0]           pix_bytes,
  output logic                 busy,
  output logic                 op_done,
  output logic                 op_error,
  output logic                 mem_rd_en,
  output logic [AW-1:0]        mem_rd_addr,
  input  logic [7:0]           mem_rd_data,
  output logic                 mem_wr_en,
  output logic [AW-1:0]        mem_wr_addr,
  output logic [7:0]           mem_wr_data,
  input  logic                 flush,
  input  logic                 invalidate,
  output logic                 upd_valid,
  output logic [CW-1:0]        upd_x,
  output logic [CW-1:0]        upd_y,
  output logic [CW-1:0]        upd_w,
  output logic [CW-1:0]        upd_h
);
  localparam int EW = 4 * CW;

  logic          push;
  logic [EW-1:0] push_rect, upd_data;

  fbr_core #(.CW(CW), .AW(AW), .MAX_W(MAX_W), .MAX_H(MAX_H)) u_core (
    .clk(clk), .rst(rst), .start(op_start), .kind(op_kind), .colour(op_colour),
    .sx(src_x), .sy(src_y), .dx(dst_x), .dy(dst_y), .w(rect_w), .h(rect_h),
    .surf_w(surf_w), .surf_h(surf_h), .stride(line_stride), .bpp(pix_bytes),
    .busy(busy), .done(op_done), .error(op_error),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .push(push), .push_rect(push_rect));

  fbr_dirty_ring #(.EW(EW), .DEPTH(DQ_DEPTH)) u_ring (
    .clk(clk), .rst(rst), .push(push), .push_data(push_rect),
    .flush(flush), .invalidate(invalidate),
    .upd_valid(upd_valid), .upd_data(upd_data));

  assign upd_x = upd_data[4*CW-1 -: CW];
  assign upd_y = upd_data[3*CW-1 -: CW];
  assign upd_w = upd_data[2*CW-1 -: CW];
  assign upd_h = upd_data[CW-1:0];
endmodule

// File: tb/fb_rect_engine_tb.sv
`timescale 1ns/1ps
module fb_rect_engine_tb;
  localparam int CW = 16, AW = 16, DEPTH = 8, MEMB = 8192;
  localparam int SW = 40, SH = 30, STRIDE = 160;

  logic clk = 1'b0, rst = 1'b1;
  logic op_start = 1'b0, op_kind = 1'b0;
  logic [31:0] op_colour = '0;
  logic signed [CW-1:0] src_x = '0, src_y = '0, dst_x = '0, dst_y = '0, rect_w = '0, rect_h = '0;
  logic [2:0] pix_bytes = 3'd1;
  logic flush = 1'b0, invalidate = 1'b0;
  logic busy, op_done, op_error, mem_rd_en, mem_wr_en, upd_valid;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [7:0] mem_wr_data, mem_rd_data;
  logic [CW-1:0] upd_x, upd_y, upd_w, upd_h;

  always #2 clk = ~clk;

  fb_rect_engine #(.CW(CW), .AW(AW), .MAX_W(64), .MAX_H(48), .DQ_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .op_start(op_start), .op_kind(op_kind), .op_colour(op_colour),
    .src_x(src_x), .src_y(src_y), .dst_x(dst_x), .dst_y(dst_y), .rect_w(rect_w), .rect_h(rect_h),
    .surf_w(CW'(SW)), .surf_h(CW'(SH)), .line_stride(AW'(STRIDE)), .pix_bytes(pix_bytes),
    .busy(busy), .op_done(op_done), .op_error(op_error),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .flush(flush), .invalidate(invalidate), .upd_valid(upd_valid),
    .upd_x(upd_x), .upd_y(upd_y), .upd_w(upd_w), .upd_h(upd_h));

  function automatic logic [7:0] pat(int i);
    return 8'(i * 7 + 3);
  endfunction

  logic [7:0] fbm [MEMB];
  logic [7:0] expm [MEMB];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MEMB; i++) fbm[i] <= pat(i);
    end else begin
      if (mem_wr_en) fbm[int'(mem_wr_addr) % MEMB] <= mem_wr_data;
      if (mem_rd_en) mem_rd_data <= fbm[int'(mem_rd_addr) % MEMB];
    end
  end

  int checks = 0, fails = 0, done_cnt = 0;
  bit finished = 0;
  logic [63:0] sbq[$];
  logic [63:0] pend[$];

  task automatic chk(bit ok, string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  always @(negedge clk) if (!rst && op_done) done_cnt++;

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && upd_valid) begin
      if (sbq.size() == 0) chk(0, "R9/R10 unexpected update", {upd_x, upd_y, upd_w, upd_h}, '0);
      else begin
        logic [63:0] e;
        e = sbq.pop_front();
        chk({upd_x, upd_y, upd_w, upd_h} == e, "R8 update rect", {upd_x, upd_y, upd_w, upd_h}, e);
      end
    end
  end

  task automatic mem_cmp(string tag);
    int bad = -1;
    for (int i = 0; i < MEMB; i++) if (fbm[i] !== expm[i] && bad < 0) bad = i;
    chk(bad < 0, tag, (bad < 0) ? 64'd0 : 64'(fbm[bad]), (bad < 0) ? 64'd0 : 64'(expm[bad]));
  endtask

  task automatic model(bit kind, logic [31:0] col, int sx, int sy, int dx, int dy, int w, int h, int bpp);
    logic [7:0] tmp[$];
    if (!kind) begin
      for (int r = 0; r < h; r++)
        for (int c = 0; c < w * bpp; c++)
          expm[bpp * dx + STRIDE * (dy + r) + c] = col[8 * (c % bpp) +: 8];
    end else begin
      for (int r = 0; r < h; r++)
        for (int c = 0; c < w * bpp; c++) tmp.push_back(expm[bpp * sx + STRIDE * (sy + r) + c]);
      for (int r = 0; r < h; r++)
        for (int c = 0; c < w * bpp; c++) expm[bpp * dx + STRIDE * (dy + r) + c] = tmp[r * w * bpp + c];
    end
  endtask

  task automatic wait_end(output bit got_err, input string tag);
    int n = 0;
    got_err = 0;
    while (!op_done && !op_error && n < 5000) begin @(negedge clk); n++; end
    got_err = op_error;
    if (n >= 5000) chk(0, {tag, " timeout"}, 0, 1);
  endtask

  task automatic do_op(bit kind, logic [31:0] col, int sx, int sy, int dx, int dy, int w, int h,
                       int bpp, bit ok, string tag);
    bit got_err;
    @(negedge clk);
    op_kind = kind; op_colour = col; src_x = CW'(sx); src_y = CW'(sy);
    dst_x = CW'(dx); dst_y = CW'(dy); rect_w = CW'(w); rect_h = CW'(h); pix_bytes = 3'(bpp);
    op_start = 1'b1;
    @(negedge clk);
    op_start = 1'b0;
    wait_end(got_err, tag);
    chk(got_err == !ok, {tag, " completion kind"}, 64'(got_err), 64'(!ok));
    @(negedge clk);
    chk(!op_done && !op_error, "R7 pulse width", 64'(op_done), 0);
    if (ok) begin
      model(kind, col, sx, sy, dx, dy, w, h, bpp);
      pend.push_back({16'(dx), 16'(dy), 16'(w), 16'(h)});
    end
    repeat (3) @(negedge clk);
    mem_cmp({tag, " memory"});
  endtask

  task automatic do_flush(bit inv);
    int k;
    if (!inv) begin
      k = pend.size() % DEPTH;
      for (int i = pend.size() - k; i < pend.size(); i++) sbq.push_back(pend[i]);
    end
    pend.delete();
    @(negedge clk);
    flush = 1'b1; invalidate = inv;
    @(negedge clk);
    flush = 1'b0; invalidate = 1'b0;
    repeat (40) @(negedge clk);
    chk(sbq.size() == 0, "R8 all queued rects emitted", 64'(sbq.size()), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int d0;
    bit ge;
    for (int i = 0; i < MEMB; i++) expm[i] = pat(i);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !op_done && !op_error && !upd_valid, "R12 reset state",
        {60'd0, busy, op_done, op_error, upd_valid}, 0);
    do_flush(0); // R12 empty ring emits nothing
    mem_cmp("R12 memory untouched");

    do_op(0, 32'h11223344, 0, 0, 2, 3, 5, 4, 4, 1, "R3 fill bpp4");
    do_op(0, 32'hA1B2C3D4, 0, 0, 10, 0, 7, 2, 3, 1, "R3 fill bpp3");
    do_op(0, 32'h0000005A, 0, 0, 39, 29, 1, 1, 1, 1, "R1 R3 fill corner");
    do_op(0, 32'h0000BEEF, 0, 0, 0, 20, 40, 2, 2, 1, "R3 fill full width");
    do_flush(0); // R8

    do_op(1, 0, 2, 3, 20, 10, 5, 4, 4, 1, "R4 copy disjoint");
    do_op(1, 0, 0, 5, 1, 7, 6, 5, 2, 1, "R5 copy overlap down");
    do_op(1, 0, 3, 12, 2, 9, 6, 5, 2, 1, "R5 copy overlap up");
    do_op(1, 0, 4, 15, 6, 15, 8, 3, 3, 1, "R6 copy same row");
    do_flush(1); // R9 drop
    do_flush(0); // R9 nothing of the dropped set

    do_op(0, 32'h77, 0, 0, 35, 0, 6, 1, 1, 0, "R1 x+w over surface");
    do_op(0, 32'h77, 0, 0, -1, 0, 2, 1, 1, 0, "R1 negative x");
    do_op(0, 32'h77, 0, 0, 0, 0, 65, 1, 1, 0, "R1 w over max");
    do_op(0, 32'h77, 0, 0, 0, 25, 2, 6, 1, 0, "R1 y+h over surface");
    do_op(1, 0, 0, 28, 0, 0, 3, 4, 1, 0, "R4 copy source out of bounds");
    do_op(0, 32'h77, 0, 0, 0, 0, 2, 2, 0, 0, "R2 zero bytes per pixel");
    do_op(0, 32'h77, 0, 0, 0, 0, 2, 2, 5, 0, "R2 five bytes per pixel");
    do_op(0, 32'h99, 0, 0, 5, 5, 0, 3, 1, 1, "R11 zero width");

    // R7 start while busy is ignored
    d0 = done_cnt;
    @(negedge clk);
    op_kind = 0; op_colour = 32'h3C; dst_x = 16'sd0; dst_y = 16'sd1; rect_w = 16'sd4;
    rect_h = 16'sd2; pix_bytes = 3'd1; op_start = 1'b1;
    @(negedge clk);
    op_colour = 32'hEE; dst_x = 16'sd30; dst_y = 16'sd0; rect_w = 16'sd2; rect_h = 16'sd1;
    @(negedge clk);
    op_start = 1'b0;
    wait_end(ge, "R7 busy op");
    model(0, 32'h3C, 0, 0, 0, 1, 4, 2, 1);
    pend.push_back({16'd0, 16'd1, 16'd4, 16'd2});
    repeat (60) @(negedge clk);
    chk(done_cnt == d0 + 1, "R7 single completion", 64'(done_cnt - d0), 1);
    mem_cmp("R7 ignored start memory");
    do_flush(0);

    // R10 wrap: nine pushes into an eight-entry ring
    for (int i = 0; i < 9; i++) do_op(0, 32'(i + 1), 0, 0, i, 29, 1, 1, 1, 1, "R10 wrap fill");
    do_flush(0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule